// File: doc/BRIEF.md
# Opportunistic Store Verify Scheduler

This block holds stores that have both an address and data and are waiting to commit. It decides, store by store, whether the cache write is needed. In every cycle it looks at the data cache read ports. A port may be left unused after all ready loads and stores have been granted. When that happens, the block sends a verify read for the oldest store that has not yet been checked.

One cycle after issue, the cache returns the read word and a hit flag. The block compares the enabled bytes of the returned word with the store data and records the store as silent or non-silent. A miss tells the block nothing, so the store is recorded as non-silent.

At commit, the oldest store leaves the table. A store recorded as silent is squashed, and the block raises a squash pulse in place of the write. Any other store is written normally. This covers stores never checked, stores whose verify read is still in flight, and stores whose verify missed. The verify reads only use port slots that are already free, so they never delay any ready access.

Top module: `ssv_sched`

## Requirements
- R1: After reset the table is empty, `tbl_full` is 0, and `vfy_valid`, `wr_en` and `squash` are 0.
- R2: A verify read is issued only when fewer than NPORT demand requests are raised in that cycle. It uses the lowest-numbered port whose `dem_req` bit is 0. With two ports, that is port 1 when `dem_req[0]` is 1 and port 0 otherwise.
- R3: When a verify is issued, it targets the oldest store in the table that is unverified and has no verify in flight. A store committing in the same cycle is never a target.
- R4: A store is recorded silent when its verify returns `rsp_hit`=1 and every enabled byte of `rsp_data` equals the store data. At commit, such a store gives `squash`=1 and `wr_en`=0.
- R5: At commit, a store that is not silent gives `wr_en`=1 and `squash`=0. In that same cycle `wr_addr`, `wr_data` and `wr_be` carry the store's address, data and byte enables.
- R6: A verify response with `rsp_hit`=0 records the store as non-silent.
- R7: A store that commits before its verify was issued is treated as non-silent. So is a store that commits in the cycle its verify response returns.
- R8: The compare ignores bytes whose enable bit is 0. Byte i is bits 8i+7 down to 8i, and `be` bit i enables it.
- R9: `tbl_full` is 1 exactly when DEPTH stores are held. An allocation while full is dropped. A commit while the table is empty produces neither a write nor a squash.
- R10: At most one verify is issued per cycle, and a store that has been verified is never verified again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Insert a new store at the young end |
| alloc_addr | input | ADDR_W | Store address |
| alloc_data | input | DATA_W | Store data word |
| alloc_be | input | DATA_W/8 | Store byte enables |
| tbl_full | output | 1 | Table holds DEPTH stores |
| dem_req | input | NPORT | Ready loads/stores claiming each cache port this cycle |
| vfy_valid | output | 1 | Verify read issued this cycle |
| vfy_port | output | max(1,clog2(NPORT)) | Port used by the verify read |
| vfy_addr | output | ADDR_W | Address of the verify read |
| rsp_hit | input | 1 | Verify read hit, valid the cycle after issue |
| rsp_data | input | DATA_W | Verify read word, valid the cycle after issue |
| commit_valid | input | 1 | Oldest store commits this cycle |
| wr_en | output | 1 | Perform the cache write of the committing store |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | DATA_W | Write data |
| wr_be | output | DATA_W/8 | Write byte enables |
| squash | output | 1 | Committing store was silent and its write is dropped |

## Verification
The demand-port pattern is drawn at random, so no-port, one-port and two-port cycles all occur. These cycles show whether verifies are held back when both ports are busy, and which free port a verify takes. Verify responses are drawn from three kinds of word: an exact copy of the store data, a word that differs only in disabled bytes, and a word that differs in an enabled byte. Each kind may also come back as a miss. Together these kinds separate masked from full-word comparison and a hit from a miss. Commits fall at random relative to issue and response, so stores commit unverified, in flight, or already verified. Directed runs fill the table past capacity and commit from an empty table.

// File: rtl/ssv_pkg.sv
package ssv_pkg;
    localparam int ADDR_W_DEF = 32;
    localparam int DATA_W_DEF = 64;
    localparam int DEPTH_DEF  = 8;
    localparam int NPORT_DEF  = 2;

    typedef enum logic [1:0] {
        ST_PEND = 2'd0,
        ST_SIL  = 2'd1,
        ST_NSIL = 2'd2
    } vstate_e;
endpackage

// File: rtl/ssv_port_arb.sv
module ssv_port_arb #(
    parameter int NPORT = 2,
    parameter int PW    = 1
) (
    input  logic [NPORT-1:0] dem_req,
    output logic             free,
    output logic [PW-1:0]    idx
);
    always_comb begin
        free = 1'b0;
        idx  = '0;
        for (int p = NPORT - 1; p >= 0; p--) begin
            if (!dem_req[p]) begin
                free = 1'b1;
                idx  = PW'(p);
            end
        end
    end
endmodule

// File: rtl/ssv_oldest_pick.sv
module ssv_oldest_pick #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3
) (
    input  logic [DEPTH-1:0] elig,
    input  logic [IDX_W-1:0] head,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    logic [IDX_W-1:0] j;

    always_comb begin
        found = 1'b0;
        idx   = head;
        j     = head;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            j = head + IDX_W'(k);
            if (elig[j]) begin
                found = 1'b1;
                idx   = j;
            end
        end
    end
endmodule

// File: rtl/ssv_mask_cmp.sv
module ssv_mask_cmp #(
    parameter int DATA_W = 64,
    parameter int BE_W   = DATA_W / 8
) (
    input  logic [DATA_W-1:0] st_data,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [BE_W-1:0]   be,
    input  logic              hit,
    output logic              silent
);
    logic [BE_W-1:0] byte_ok;

    for (genvar b = 0; b < BE_W; b++) begin : g_byte
        assign byte_ok[b] = !be[b] || (st_data[8*b +: 8] == rd_data[8*b +: 8]);
    end

    assign silent = hit && (&byte_ok);
endmodule

// File: rtl/ssv_sched.sv
module ssv_sched #(
    parameter int ADDR_W = ssv_pkg::ADDR_W_DEF,
    parameter int DATA_W = ssv_pkg::DATA_W_DEF,
    parameter int DEPTH  = ssv_pkg::DEPTH_DEF,
    parameter int NPORT  = ssv_pkg::NPORT_DEF,
    localparam int BE_W  = DATA_W / 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1,
    localparam int PW    = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic [DATA_W-1:0] alloc_data,
    input  logic [BE_W-1:0]   alloc_be,
    output logic              tbl_full,
    input  logic [NPORT-1:0]  dem_req,
    output logic              vfy_valid,
    output logic [PW-1:0]     vfy_port,
    output logic [ADDR_W-1:0] vfy_addr,
    input  logic              rsp_hit,
    input  logic [DATA_W-1:0] rsp_data,
    input  logic              commit_valid,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [BE_W-1:0]   wr_be,
    output logic              squash
);
    import ssv_pkg::*;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [BE_W-1:0]   be;
        vstate_e           st;
    } ent_t;

    typedef struct packed {
        ent_t [DEPTH-1:0] ent;
        logic [DEPTH-1:0] vld;
        logic [IDX_W-1:0] head;
        logic [IDX_W-1:0] tail;
        logic [CNT_W-1:0] cnt;
        logic             fl_vld;
        logic [IDX_W-1:0] fl_idx;
    } state_t;

    state_t s_q, s_d;

    logic             port_free;
    logic [PW-1:0]    port_idx;
    logic [DEPTH-1:0] elig;
    logic             pick_found;
    logic [IDX_W-1:0] pick_idx;
    logic             rsp_silent;
    logic             commit_fire;
    logic             alloc_ok;
    logic             rsp_apply;
    ent_t             head_ent;
    ent_t             fl_ent;

    ssv_port_arb #(.NPORT(NPORT), .PW(PW)) u_arb (
        .dem_req (dem_req),
        .free    (port_free),
        .idx     (port_idx)
    );

    ssv_oldest_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_pick (
        .elig  (elig),
        .head  (s_q.head),
        .found (pick_found),
        .idx   (pick_idx)
    );

    assign fl_ent = s_q.ent[s_q.fl_idx];

    ssv_mask_cmp #(.DATA_W(DATA_W), .BE_W(BE_W)) u_cmp (
        .st_data (fl_ent.data),
        .rd_data (rsp_data),
        .be      (fl_ent.be),
        .hit     (rsp_hit),
        .silent  (rsp_silent)
    );

    always_comb begin
        s_d         = s_q;
        head_ent    = s_q.ent[s_q.head];
        commit_fire = commit_valid && (s_q.cnt != '0);
        alloc_ok    = alloc_valid && (s_q.cnt != CNT_W'(DEPTH));
        squash      = commit_fire && (head_ent.st == ST_SIL);
        wr_en       = commit_fire && !squash;
        wr_addr     = head_ent.addr;
        wr_data     = head_ent.data;
        wr_be       = head_ent.be;
        tbl_full    = (s_q.cnt == CNT_W'(DEPTH));

        for (int i = 0; i < DEPTH; i++) begin
            elig[i] = s_q.vld[i] && (s_q.ent[i].st == ST_PEND)
                      && !(s_q.fl_vld && (s_q.fl_idx == IDX_W'(i)))
                      && !(commit_fire && (s_q.head == IDX_W'(i)));
        end

        vfy_valid = port_free && pick_found;
        vfy_port  = port_idx;
        vfy_addr  = s_q.ent[pick_idx].addr;

        rsp_apply = s_q.fl_vld && !(commit_fire && (s_q.head == s_q.fl_idx));
        if (rsp_apply) begin
            s_d.ent[s_q.fl_idx].st = rsp_silent ? ST_SIL : ST_NSIL;
        end

        if (commit_fire) begin
            s_d.vld[s_q.head] = 1'b0;
            s_d.head          = s_q.head + 1'b1;
        end

        if (alloc_ok) begin
            s_d.ent[s_q.tail].addr = alloc_addr;
            s_d.ent[s_q.tail].data = alloc_data;
            s_d.ent[s_q.tail].be   = alloc_be;
            s_d.ent[s_q.tail].st   = ST_PEND;
            s_d.vld[s_q.tail]      = 1'b1;
            s_d.tail               = s_q.tail + 1'b1;
        end

        s_d.cnt    = s_q.cnt + CNT_W'(alloc_ok) - CNT_W'(commit_fire);
        s_d.fl_vld = vfy_valid;
        s_d.fl_idx = pick_idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R2: the verify port is never one claimed by a demand access
    p_port_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vfy_valid |-> !dem_req[vfy_port]);

    // R2: all ports claimed means no verify
    p_busy_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(dem_req) == NPORT) |-> !vfy_valid);

    // R4/R5: a commit yields exactly one of write or squash
    p_one_outcome_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid && s_q.cnt != '0) |-> $onehot({wr_en, squash}));

    // R7: a store whose verify is still returning is written
    p_inflight_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid && s_q.cnt != '0 && s_q.fl_vld && s_q.fl_idx == s_q.head) |-> wr_en);

    // R9: occupancy bounded and empty commits do nothing
    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_W'(DEPTH));
    p_empty_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt == '0) |-> !(wr_en || squash));

    // R10: a verify only targets a valid, still-unverified store
    p_target_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
        vfy_valid |-> (s_q.vld[pick_idx] && s_q.ent[pick_idx].st == ST_PEND));

    // R6: a miss never leaves the store marked silent next cycle
    p_miss_loud_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_apply && !rsp_hit) |=> (s_q.ent[$past(s_q.fl_idx)].st == ST_NSIL));
endmodule

// File: tb/sim_ssv_sched.sv
module sim_ssv_sched;
    localparam int AW = 32;
    localparam int DW = 64;
    localparam int BW = 8;
    localparam int D  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          alloc_valid = 1'b0;
    logic [AW-1:0] alloc_addr = '0;
    logic [DW-1:0] alloc_data = '0;
    logic [BW-1:0] alloc_be = '0;
    logic          tbl_full;
    logic [1:0]    dem_req = 2'b00;
    logic          vfy_valid;
    logic [0:0]    vfy_port;
    logic [AW-1:0] vfy_addr;
    logic          rsp_hit = 1'b0;
    logic [DW-1:0] rsp_data = '0;
    logic          commit_valid = 1'b0;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic [BW-1:0] wr_be;
    logic          squash;

    always #2 clk = ~clk;

    ssv_sched u0 (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_addr(alloc_addr),
        .alloc_data(alloc_data), .alloc_be(alloc_be), .tbl_full(tbl_full),
        .dem_req(dem_req), .vfy_valid(vfy_valid), .vfy_port(vfy_port),
        .vfy_addr(vfy_addr), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
        .commit_valid(commit_valid), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_be(wr_be), .squash(squash)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [AW-1:0] m_addr [D];
    logic [DW-1:0] m_data [D];
    logic [BW-1:0] m_be   [D];
    int            m_st   [D];
    int            m_id   [D];
    int            m_n = 0;
    int            next_id = 1;
    bit            fl_v = 0;
    int            fl_id = 0;
    logic          nxt_hit = 1'b0;
    logic [DW-1:0] nxt_data = '0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic bit masked_eq(input logic [DW-1:0] a, input logic [DW-1:0] b, input logic [BW-1:0] be);
        for (int i = 0; i < BW; i++)
            if (be[i] && a[8*i +: 8] != b[8*i +: 8]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [DW-1:0] expand(input logic [BW-1:0] be);
        logic [DW-1:0] m = '0;
        for (int i = 0; i < BW; i++) if (be[i]) m[8*i +: 8] = 8'hFF;
        return m;
    endfunction

    task automatic step(input bit av, input logic [1:0] dem, input bit cmt);
        int  n0, cand, pos;
        bit  cfire, e_sq, e_wr, e_v, found;
        logic [AW-1:0] a;
        logic [DW-1:0] dd;
        logic [BW-1:0] b;
        @(negedge clk);
        a  = $urandom;
        dd = {$urandom, $urandom};
        b  = BW'($urandom % 255 + 1);
        alloc_valid  = av;
        alloc_addr   = a;
        alloc_data   = dd;
        alloc_be     = b;
        dem_req      = dem;
        commit_valid = cmt;
        rsp_hit      = fl_v ? nxt_hit : 1'($urandom);
        rsp_data     = fl_v ? nxt_data : {$urandom, $urandom};
        #1;
        n0    = m_n;
        cfire = cmt && (n0 > 0);
        e_sq  = cfire && (m_st[0] == 1);
        e_wr  = cfire && !e_sq;
        chk(squash == e_sq, "R4 squash", 64'(squash), 64'(e_sq));
        chk(wr_en == e_wr, "R5/R7 wr_en", 64'(wr_en), 64'(e_wr));
        if (e_wr) begin
            chk(wr_addr == m_addr[0], "R5 wr_addr", 64'(wr_addr), 64'(m_addr[0]));
            chk(wr_data == m_data[0], "R5 wr_data", wr_data, m_data[0]);
            chk(wr_be == m_be[0], "R5 wr_be", 64'(wr_be), 64'(m_be[0]));
        end
        found = 0;
        cand  = 0;
        for (int k = 0; k < n0; k++) begin
            if (!found && m_st[k] == 0 && !(fl_v && m_id[k] == fl_id) && !(cfire && k == 0)) begin
                found = 1;
                cand  = k;
            end
        end
        e_v = (dem != 2'b11) && found;
        chk(vfy_valid == e_v, "R2/R3 vfy_valid", 64'(vfy_valid), 64'(e_v));
        if (e_v) begin
            chk(vfy_addr == m_addr[cand], "R3 vfy_addr", 64'(vfy_addr), 64'(m_addr[cand]));
            chk(vfy_port == (dem[0] ? 1'b1 : 1'b0), "R2 vfy_port", 64'(vfy_port), 64'(dem[0]));
        end
        chk(tbl_full == (n0 == D), "R9 tbl_full", 64'(tbl_full), 64'(n0 == D));

        // response lands (R4 R6 R7 R8)
        if (fl_v) begin
            for (int k = 0; k < n0; k++)
                if (m_id[k] == fl_id && !(cfire && k == 0))
                    m_st[k] = (nxt_hit && masked_eq(m_data[k], nxt_data, m_be[k])) ? 1 : 2;
        end
        // next response
        fl_v = e_v;
        if (e_v) begin
            int kind = $urandom % 3;
            fl_id   = m_id[cand];
            nxt_hit = ($urandom % 5) != 0;
            if (kind == 0) nxt_data = m_data[cand];
            else if (kind == 1) nxt_data = m_data[cand] ^ ({$urandom, $urandom} & ~expand(m_be[cand]));
            else begin
                pos = 0;
                for (int i = BW - 1; i >= 0; i--) if (m_be[cand][i]) pos = i;
                nxt_data = m_data[cand] ^ (64'h1 << (8 * pos));
            end
        end
        if (cfire) begin
            for (int k = 0; k < D - 1; k++) begin
                m_addr[k] = m_addr[k+1]; m_data[k] = m_data[k+1];
                m_be[k] = m_be[k+1]; m_st[k] = m_st[k+1]; m_id[k] = m_id[k+1];
            end
            m_n--;
        end
        if (av && n0 < D) begin
            m_addr[m_n] = a; m_data[m_n] = dd; m_be[m_n] = b;
            m_st[m_n] = 0; m_id[m_n] = next_id++;
            m_n++;
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        #1;
        chk(!vfy_valid && !wr_en && !squash && !tbl_full, "R1 reset outputs",
            64'({vfy_valid, wr_en, squash, tbl_full}), 64'h0);
        @(negedge clk);
        rst_n = 1'b1;
        // R9: fill past capacity while ports are busy
        for (int i = 0; i < D + 2; i++) step(1'b1, 2'b11, 1'b0);
        // R7: commit everything unverified
        for (int i = 0; i < D; i++) step(1'b0, 2'b11, 1'b1);
        // R9: commit on empty table
        step(1'b0, 2'b00, 1'b1);
        step(1'b0, 2'b00, 1'b1);
        // random mix covering R2-R8 and R10
        for (int i = 0; i < 4000; i++)
            step(($urandom % 2) == 0, 2'($urandom), ($urandom % 10) < 3);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule